// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

The controller gathers 64 interrupt request lines into two banks of 32 bits and drives one interrupt request toward a processor. Every line passes a two-flop synchroniser. After that, its live value is recorded in the bank's level register. A rising edge on a line whose bit is configured as edge-type latches a sticky event bit. A bit configured as level-type never latches an event. Instead, its live level feeds the pending logic directly. The edge/level configuration is fixed at build time.

Software works through a small 32-bit register port that uses valid, write, address and data signals. It can read the latched events, the mask and the live levels of each bank. It can write the mask. It can write an acknowledge word that clears latched events. The acknowledge word never touches level-type bits. The processor request is registered. It is high when any bank has an enabled bit that is either a latched event or an active level-type input.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, every event, mask and level register reads 0, and `cpu_irq` is 0.
- R2: Input line n lands in bank (1 - n/32), at bit n mod 32. Lines 0..31 therefore go to bank 1 and lines 32..63 to bank 0. Bank k is addressed when addr[11:4] equals k+1: bank 0 occupies 0x010..0x01F and bank 1 occupies 0x020..0x02F.
- R3: Register offsets use addr[3:0], with a fixed meaning for each value:
  - 0x0 reads the events.
  - 0x4 reads and writes the mask.
  - 0x8 is the write-only acknowledge.
  - 0xC reads the levels.
  
  A rising edge on an edge-type line sets its event bit. An input that stays high does not set the bit again after it is acknowledged.
- R4: The level bit of each line follows the synchronised input. When a line falls, only its level bit clears. A latched event stays set.
- R5: Writing to offset 0x8 clears each event bit for which the written word holds a 1. Level-type bits are left unchanged. The level-type configuration is bits 20..28 of bank 1 (lines 20..28); every other bit is edge-type. A level-type line never sets its event bit.
- R6: A bank is pending when (events | (levels & level_type)) & mask is nonzero. `cpu_irq` is the OR of both banks. The mask reads back the value last written to it.
- R7: An address whose bank index is invalid reads 0 and ignores writes. This covers addr[11:4] equal to 0, or greater than 2. Offsets other than 0x0, 0x4, 0x8 and 0xC read 0 and ignore writes, and a read of 0x8 also returns 0.
- R8: If an acknowledge clears an event bit in the same cycle that a new edge sets it, the bit ends up set.
- R9: `cpu_irq` is registered. It changes one clock after the register update that causes the change.
- R10: A masked-in level-type line holds `cpu_irq` high for as long as the line is high, and `cpu_irq` falls after the line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq | input | 64 | Asynchronous interrupt request lines |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the cycle of the access |
| cpu_irq | output | 1 | Registered interrupt request to the processor |

## Verification
A corrupted event bit shows up in two places: in a read of offset 0x0 of its bank, and, if its mask bit is set, at `cpu_irq` one clock after the faulty update. A wrong level bit shows up in a read of offset 0xC, three clocks after the input changes. A lost or wrongly cleared event cannot recover by itself, because events only clear on an acknowledge. The bench therefore reads every bank register after each scenario, and it observes `cpu_irq` in both the cycle before and the cycle after each mask update.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int BANKS     = 2;
    localparam int BANK_W    = 32;
    localparam int LINES     = BANKS * BANK_W;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int SYNC_LEN  = 2;
    localparam int BIDX_W    = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int IDX_W     = ADDR_W - 4;

    typedef enum logic [3:0] {
        OFS_EVENT = 4'h0,
        OFS_MASK  = 4'h4,
        OFS_ACK   = 4'h8,
        OFS_LEVEL = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic [BANK_W-1:0] events;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] levels;
    } bank_state_t;

    typedef struct packed {
        logic              hit;
        logic [BIDX_W-1:0] bank;
        logic [3:0]        ofs;
    } addr_dec_t;

    // Build-time level-type configuration of a bank.
    function automatic logic [BANK_W-1:0] level_type_cfg(input int b);
        return (b == 1) ? BANK_W'(32'h1FF0_0000) : '0;
    endfunction

    // First input line that feeds bank b (higher banks take lower lines).
    function automatic int line_base(input int b);
        return (BANKS - 1 - b) * BANK_W;
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W     = 64,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= din;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/irqc_addr_dec.sv
module irqc_addr_dec
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output addr_dec_t         dec
);
    logic [IDX_W-1:0] field;
    logic [IDX_W-1:0] idx;

    always_comb begin
        field    = addr[ADDR_W-1:4];
        idx      = field - IDX_W'(1);
        dec.hit  = (field != '0) && (idx < IDX_W'(BANKS));
        dec.bank = idx[BIDX_W-1:0];
        dec.ofs  = addr[3:0];
    end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [BANK_W-1:0] LEVEL_TYPE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] line_in,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [BANK_W-1:0] wdata,
    output bank_state_t       st,
    output logic              pending
);
    logic [BANK_W-1:0] rise;
    logic [BANK_W-1:0] ack_bits;
    logic [BANK_W-1:0] ev_nxt;

    always_comb begin
        rise     = line_in & ~st.levels & ~LEVEL_TYPE;
        ack_bits = ack_we ? (wdata & ~LEVEL_TYPE) : '0;
        // a new edge wins over a simultaneous acknowledge
        ev_nxt   = (st.events & ~ack_bits) | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.events <= ev_nxt;
            st.levels <= line_in;
            if (mask_we) begin
                st.mask <= wdata;
            end
        end
    end

    assign pending = |((st.events | (st.levels & LEVEL_TYPE)) & st.mask);
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
module dual_bank_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  src_irq,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_irq
);
    logic [LINES-1:0] src_sync;
    addr_dec_t        dec;
    bank_state_t      st   [BANKS];
    logic [BANKS-1:0] pend;
    logic             pend_any;
    logic             wr_hit;

    irqc_sync #(.W(LINES), .DEPTH(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (src_irq),
        .dout(src_sync)
    );

    irqc_addr_dec u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    assign wr_hit = bus_valid && bus_write && dec.hit;

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            localparam int BASE = line_base(b);
            logic sel;
            assign sel = wr_hit && (dec.bank == BIDX_W'(b));

            irqc_bank #(.LEVEL_TYPE(level_type_cfg(b))) u_bank (
                .clk    (clk),
                .rst    (rst),
                .line_in(src_sync[BASE +: BANK_W]),
                .mask_we(sel && (dec.ofs == OFS_MASK)),
                .ack_we (sel && (dec.ofs == OFS_ACK)),
                .wdata  (bus_wdata[BANK_W-1:0]),
                .st     (st[b]),
                .pending(pend[b])
            );
        end
    endgenerate

    assign pend_any = |pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_irq <= 1'b0;
        end else begin
            cpu_irq <= pend_any;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && dec.hit) begin
            case (dec.ofs)
                OFS_EVENT: bus_rdata = DATA_W'(st[dec.bank].events);
                OFS_MASK:  bus_rdata = DATA_W'(st[dec.bank].mask);
                OFS_LEVEL: bus_rdata = DATA_W'(st[dec.bank].levels);
                default:   bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_irq,
    input logic              pend_any,
    input bank_state_t       st0,
    input bank_state_t       st1
);
    logic bad_bank;
    logic ack0, ack1, mwr0;

    assign bad_bank = (bus_addr[11:4] == 8'd0) || (bus_addr[11:4] > 8'd2);
    assign ack0 = bus_valid && bus_write && (bus_addr == 12'h018);
    assign ack1 = bus_valid && bus_write && (bus_addr == 12'h028);
    assign mwr0 = bus_valid && bus_write && (bus_addr == 12'h014);

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq == $past(pend_any)));

    // R5
    lvl_no_event_chk: assert property (@(posedge clk) disable iff (rst)
        (st1.events & level_type_cfg(1)) == '0);

    // R7
    bad_bank_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bad_bank) |-> (bus_rdata == '0));

    // R4
    bank0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ack0 |=> (($past(st0.events) & ~st0.events) == '0));

    // R4
    bank1_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !ack1 |=> (($past(st1.events) & ~st1.events) == '0));

    // R6
    mask_wr_chk: assert property (@(posedge clk) disable iff (rst)
        mwr0 |=> (st0.mask == $past(bus_wdata)));
endmodule

bind dual_bank_irq_ctrl irqc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cpu_irq  (cpu_irq),
    .pend_any (pend_any),
    .st0      (st[0]),
    .st1      (st[1])
);

// File: tb/dual_bank_irq_ctrl_bench.sv
`timescale 1ns/1ps
module dual_bank_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_irq = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dual_bank_irq_ctrl u_dual_bank_irq_ctrl (
        .clk(clk), .rst(rst), .src_irq(src_irq),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_valid = 1'b0;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        src_irq[n] = v;
        idle(5);
    endtask

    task automatic t_reset;
        check("R1 irq in reset", {31'd0, cpu_irq}, 32'd0);
        @(negedge clk); rst = 1'b0;
        rd_chk("R1 ev0", 12'h010, 0); rd_chk("R1 mask0", 12'h014, 0);
        rd_chk("R1 lvl0", 12'h01C, 0); rd_chk("R1 ev1", 12'h020, 0);
        rd_chk("R1 mask1", 12'h024, 0); rd_chk("R1 lvl1", 12'h02C, 0);
        check("R1 irq", {31'd0, cpu_irq}, 32'd0);
    endtask

    task automatic t_map;
        set_line(5, 1'b1);
        rd_chk("R2 ev1 line5", 12'h020, 32'h20);
        rd_chk("R2 lvl1 line5", 12'h02C, 32'h20);
        rd_chk("R2 ev0 untouched", 12'h010, 0);
        set_line(40, 1'b1);
        rd_chk("R2 ev0 line40", 12'h010, 32'h100);
        rd_chk("R2 lvl0 line40", 12'h01C, 32'h100);
    endtask

    task automatic t_edge;
        wr(12'h028, 32'h20);
        idle(4);
        rd_chk("R3 held high no re-set", 12'h020, 0);
        rd_chk("R4 level still high", 12'h02C, 32'h20);
        set_line(40, 1'b0);
        rd_chk("R4 fall keeps event", 12'h010, 32'h100);
        rd_chk("R4 fall clears level", 12'h01C, 0);
        wr(12'h018, 32'h100);
        rd_chk("R5 ack clears", 12'h010, 0);
        set_line(5, 1'b0);
    endtask

    task automatic t_level;
        set_line(22, 1'b1);
        rd_chk("R5 level type no event", 12'h020, 0);
        rd_chk("R5 level bit", 12'h02C, 32'h0040_0000);
        check("R6 masked off", {31'd0, cpu_irq}, 0);
        wr(12'h024, 32'h0040_0000);
        idle(1);
        check("R10 level irq", {31'd0, cpu_irq}, 1);
        wr(12'h028, 32'hFFFF_FFFF);
        idle(2);
        check("R5 ack ignores level type", {31'd0, cpu_irq}, 1);
        set_line(22, 1'b0);
        check("R10 irq drops with line", {31'd0, cpu_irq}, 0);
        wr(12'h024, 0);
    endtask

    task automatic t_mask;
        set_line(33, 1'b1);
        set_line(33, 1'b0);
        rd_chk("R6 event latched", 12'h010, 32'h2);
        check("R6 unmasked no irq", {31'd0, cpu_irq}, 0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h014; bus_wdata = 32'h2;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R9 irq one cycle late", {31'd0, cpu_irq}, 0);
        @(negedge clk);
        check("R9 irq after lag", {31'd0, cpu_irq}, 1);
        rd_chk("R6 mask readback", 12'h014, 32'h2);
        wr(12'h018, 32'h2);
        idle(1);
        check("R6 irq off after ack", {31'd0, cpu_irq}, 0);
        wr(12'h014, 0);
    endtask

    task automatic t_invalid;
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'h015, 32'hFFFF_FFFF);
        rd_chk("R7 mask0 unchanged", 12'h014, 0);
        rd_chk("R7 mask1 unchanged", 12'h024, 0);
        rd_chk("R7 bank2 read", 12'h034, 0);
        rd_chk("R7 ack offset read", 12'h028, 0);
        wr(12'h024, 32'h1234_5678);
        rd_chk("R7 odd offset read", 12'h025, 0);
        rd_chk("R7 low bank read", 12'h004, 0);
        wr(12'h024, 0);
    endtask

    task automatic t_same_cycle;
        set_line(0, 1'b1);
        set_line(0, 1'b0);
        rd_chk("R8 pre event", 12'h020, 32'h1);
        @(negedge clk); src_irq[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 12'h028; bus_wdata = 32'h1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        rd_chk("R8 set beats ack", 12'h020, 32'h1);
        wr(12'h028, 32'h1);
        idle(3);
        rd_chk("R3 ack while held", 12'h020, 0);
    endtask

    initial begin
        fork
            begin
                idle(3);
                t_reset();
                t_map();
                t_edge();
                t_level();
                t_mask();
                t_invalid();
                t_same_cycle();
            end
            begin
                idle(20000);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule